// File: doc/BRIEF.md
# SD Card Single-Block Write Sequencer

This block runs the host side of a one-block write to a memory card. Software loads a byte count, a card address argument and a data timeout into registers, then writes a command word. When that word asks for a response and is enabled, the block presents the command on a simple command handshake and holds it there. It waits until the command path reports the end of the response, and then sets a sticky response-end flag.

Only after that flag is set does the block accept a data-control word. The word selects direction, mode, DMA use and a block-size exponent. If the settings are legal, the block opens a data window. Words then pass from a DMA-style word source to the card-side data sink under valid/ready flow control. The window closes when the programmed length has moved, which raises a block-end flag, or when the timeout runs out, which raises a timeout flag. Illegal settings raise a reject flag and move no data. All flags stay set until software clears them through a write-one-to-clear register.

Top module: `sdwr_seq`

## Requirements
- R1: While reset is held, and after it is released, `status` is zero and `cmd_valid`, `src_ready`, `dat_valid` and `dat_busy` are all low.
- R2: A write to the command register (address 3) launches a command when that word has bit 6 (wait for response) and bit 7 (command enable) both set. From the next cycle `cmd_valid` is high, `cmd_index` equals word bits 5:0 and `cmd_arg` equals the argument register (address 1). All three hold until the response ends. For a block write the index is 24.
- R3: A command word with bit 6 or bit 7 clear launches nothing: `cmd_valid` stays low.
- R4: A cycle with `cmd_valid` and `cmd_resp_end` both high drops `cmd_valid` and sets status bit 6 (response end) on the next cycle.
- R5: A data-control write (address 4) made while status bit 6 is clear is ignored: no data window opens and the status is unchanged.
- R6: The data-control word has these fields: bit 0 data enable, bit 1 direction (0 = host to card), bit 2 mode (0 = block), bit 3 DMA enable, and bits 7:4 a size code giving a block of 2^code bytes (code 9 = 512 bytes). A legal write with bit 0 set opens the data window (`dat_busy` high) on the next cycle. A write with bit 0 clear is ignored.
- R7: During the window, `dat_valid` follows `src_valid`, `src_ready` follows `dat_ready` and `dat_word` carries `src_data`. After length/4 accepted words, `dat_busy` falls and status bit 10 (block end) is set in the same cycle.
- R8: A data-control write with bit 0 set is rejected if any of these holds: direction is 1, mode is 1, DMA enable is 0, the size code is below 2, the length (address 0) is zero or not a multiple of 2^code, or the timeout (address 2) is zero. A rejected write sets status bit 11 and opens no window.
- R9: If the block is not done after as many window cycles as the timeout value, the window closes and status bit 3 (timeout) is set.
- R10: A write to address 5 clears every status bit written as one. A bit whose set event falls in the same cycle stays set.
- R11: Status bits are sticky: once set, they hold until cleared by R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 length, 1 argument, 2 timeout, 3 command, 4 data control, 5 clear) |
| reg_wdata | input | 32 | Register write data |
| status | output | 12 | Sticky flags: bit 3 timeout, bit 6 response end, bit 10 block end, bit 11 reject |
| cmd_valid | output | 1 | Command presented to the command path |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument (card address) |
| cmd_resp_end | input | 1 | Command path reports end of response |
| src_valid | input | 1 | Word source has a word |
| src_data | input | 32 | Word from the source |
| src_ready | output | 1 | Word taken from the source |
| dat_valid | output | 1 | Word offered to the card-side sink |
| dat_word | output | 32 | Word to the sink |
| dat_ready | input | 1 | Sink accepts a word |
| dat_busy | output | 1 | Data window open |

## Verification
Two faults are easy to see at the ports. A command path stuck in the busy state shows as `cmd_valid` held high after a response end. A sequencer that opens the data window too early shows as `src_ready` rising before status bit 6; both appear within one cycle of the event. A wrong word counter shows as a word count that differs from length/4 at the cycle where `dat_busy` falls. A wrong timeout counter shows as a window that stays open a different number of cycles than the programmed value. Broken flag storage shows as a bit that drops without a clear or survives one, which appears in the cycle after the clear write.

// File: rtl/sdwr_seq_pkg.sv
package sdwr_seq_pkg;

  typedef enum logic [2:0] {
    RA_LEN  = 3'd0,
    RA_ARG  = 3'd1,
    RA_TMO  = 3'd2,
    RA_CMD  = 3'd3,
    RA_DCTL = 3'd4,
    RA_CLR  = 3'd5
  } reg_addr_e;

  localparam int STAT_W  = 12;
  localparam int ST_TMO  = 3;
  localparam int ST_REND = 6;
  localparam int ST_BEND = 10;
  localparam int ST_REJ  = 11;

  localparam int CW_W     = 8;
  localparam int CW_WAITR = 6;
  localparam int CW_GO    = 7;

  localparam int DC_W     = 8;
  localparam int DC_EN    = 0;
  localparam int DC_DIR   = 1;
  localparam int DC_MODE  = 2;
  localparam int DC_DMA   = 3;
  localparam int DC_SZ_LO = 4;
  localparam int SZ_W     = 4;

endpackage

// File: rtl/sdwr_regs.sv
module sdwr_regs
  import sdwr_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              set_rend,
  input  logic              set_bend,
  input  logic              set_tmo,
  input  logic              set_rej,
  output logic [LEN_W-1:0]  len_q,
  output logic [DATA_W-1:0] arg_q,
  output logic [TMO_W-1:0]  tmo_q,
  output logic [STAT_W-1:0] status_q
);

  logic              len_en, arg_en, tmo_en, clr_we;
  logic [STAT_W-1:0] clr_mask, set_mask, keep, status_d;

  always_comb begin
    len_en   = we && (addr == RA_LEN);
    arg_en   = we && (addr == RA_ARG);
    tmo_en   = we && (addr == RA_TMO);
    clr_we   = we && (addr == RA_CLR);
    clr_mask = clr_we ? wdata[STAT_W-1:0] : '0;
    set_mask = '0;
    set_mask[ST_REND] = set_rend;
    set_mask[ST_BEND] = set_bend;
    set_mask[ST_TMO]  = set_tmo;
    set_mask[ST_REJ]  = set_rej;
    keep     = status_q & ~clr_mask;
    status_d = keep | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q    <= '0;
      arg_q    <= '0;
      tmo_q    <= '0;
      status_q <= '0;
    end else begin
      if (len_en) len_q <= wdata[LEN_W-1:0];
      if (arg_en) arg_q <= wdata;
      if (tmo_en) tmo_q <= wdata[TMO_W-1:0];
      status_q <= status_d;
    end
  end

  // R11: a set flag not named by a clear stays set
  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|keep) |=> ((status_q & $past(keep)) == $past(keep)));

  // R10: a clear with no competing set event leaves the written bits low
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && (set_mask == '0)) |=> ((status_q & $past(clr_mask)) == '0));

endmodule

// File: rtl/sdwr_cmd.sv
module sdwr_cmd
  import sdwr_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [CW_W-1:0]   cmd_word,
  input  logic [DATA_W-1:0] arg_in,
  input  logic              dat_busy,
  input  logic              resp_end,
  output logic              cmd_valid_q,
  output logic [IDX_W-1:0]  cmd_index_q,
  output logic [DATA_W-1:0] cmd_arg_q,
  output logic              rend_evt
);

  logic launch, valid_d;

  always_comb begin
    launch   = cmd_we && cmd_word[CW_GO] && cmd_word[CW_WAITR]
               && !cmd_valid_q && !dat_busy;
    rend_evt = cmd_valid_q && resp_end;
    if (launch)        valid_d = 1'b1;
    else if (rend_evt) valid_d = 1'b0;
    else               valid_d = cmd_valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid_q <= 1'b0;
      cmd_index_q <= '0;
      cmd_arg_q   <= '0;
    end else begin
      cmd_valid_q <= valid_d;
      if (launch) begin
        cmd_index_q <= cmd_word[IDX_W-1:0];
        cmd_arg_q   <= arg_in;
      end
    end
  end

  // R2: a presented command holds still until its response ends
  p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_q && !resp_end) |=>
      (cmd_valid_q && $stable(cmd_index_q) && $stable(cmd_arg_q)));

  // R3: a command appears only after a word with both launch flags
  p_cmd_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid_q) |->
      $past(cmd_we && cmd_word[CW_GO] && cmd_word[CW_WAITR]));

endmodule

// File: rtl/sdwr_dat.sv
module sdwr_dat
  import sdwr_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dctl_we,
  input  logic [DC_W-1:0]   dctl_word,
  input  logic [LEN_W-1:0]  len_in,
  input  logic [TMO_W-1:0]  tmo_in,
  input  logic              rend_flag,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  input  logic              dat_ready,
  output logic              busy_q,
  output logic              src_ready,
  output logic              dat_valid,
  output logic [DATA_W-1:0] dat_word,
  output logic              done_evt,
  output logic              tmo_evt,
  output logic              rej_evt
);

  localparam int LANE_LOG = $clog2(DATA_W / 8);
  localparam int WCNT_W   = LEN_W - LANE_LOG;

  logic [SZ_W-1:0]   sz_code;
  logic [LEN_W-1:0]  blk_mask;
  logic              arm, bad, start, xfer;
  logic              busy_d;
  logic [WCNT_W-1:0] wcnt_q, wcnt_d;
  logic [TMO_W-1:0]  tcnt_q, tcnt_d;

  always_comb begin
    sz_code  = dctl_word[DC_SZ_LO +: SZ_W];
    blk_mask = ~({LEN_W{1'b1}} << sz_code);
    arm      = dctl_we && dctl_word[DC_EN] && rend_flag && !busy_q;
    bad      = dctl_word[DC_DIR] || dctl_word[DC_MODE] || !dctl_word[DC_DMA]
               || (sz_code < SZ_W'(LANE_LOG)) || (len_in == '0)
               || (|(len_in & blk_mask)) || (tmo_in == '0);
    start    = arm && !bad;
    rej_evt  = arm && bad;

    src_ready = busy_q && dat_ready;
    dat_valid = busy_q && src_valid;
    dat_word  = src_data;

    xfer     = busy_q && src_valid && dat_ready;
    done_evt = xfer && (wcnt_q == WCNT_W'(1));
    tmo_evt  = busy_q && !done_evt && (tcnt_q == TMO_W'(1));

    if (start)                    busy_d = 1'b1;
    else if (done_evt || tmo_evt) busy_d = 1'b0;
    else                          busy_d = busy_q;

    if (start)     wcnt_d = len_in[LEN_W-1:LANE_LOG];
    else if (xfer) wcnt_d = wcnt_q - WCNT_W'(1);
    else           wcnt_d = wcnt_q;

    if (start)       tcnt_d = tmo_in;
    else if (busy_q) tcnt_d = tcnt_q - TMO_W'(1);
    else             tcnt_d = tcnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wcnt_q <= '0;
      tcnt_q <= '0;
    end else begin
      busy_q <= busy_d;
      wcnt_q <= wcnt_d;
      tcnt_q <= tcnt_d;
    end
  end

  // R7: an open window always has words left to move
  p_words_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (wcnt_q != '0));

  // R9: a timeout closes the window
  p_tmo_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> !busy_q);

  // R8: a rejected setup leaves the window closed
  p_rej_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rej_evt |=> !busy_q);

endmodule

// File: rtl/sdwr_seq.sv
module sdwr_seq
  import sdwr_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int TMO_W  = 16,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] status,
  output logic              cmd_valid,
  output logic [IDX_W-1:0]  cmd_index,
  output logic [DATA_W-1:0] cmd_arg,
  input  logic              cmd_resp_end,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic              dat_valid,
  output logic [DATA_W-1:0] dat_word,
  input  logic              dat_ready,
  output logic              dat_busy
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  logic              cmd_we, dctl_we;
  logic              rend_evt, done_evt, tmo_evt, rej_evt;
  logic [LEN_W-1:0]  len_q;
  logic [DATA_W-1:0] arg_q;
  logic [TMO_W-1:0]  tmo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  always_comb begin
    rst_n_i = rst_sync_q[1];
    cmd_we  = reg_we && (reg_addr == RA_CMD);
    dctl_we = reg_we && (reg_addr == RA_DCTL);
  end

  sdwr_regs #(.DATA_W(DATA_W), .LEN_W(LEN_W), .TMO_W(TMO_W)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .set_rend (rend_evt),
    .set_bend (done_evt),
    .set_tmo  (tmo_evt),
    .set_rej  (rej_evt),
    .len_q    (len_q),
    .arg_q    (arg_q),
    .tmo_q    (tmo_q),
    .status_q (status)
  );

  sdwr_cmd #(.DATA_W(DATA_W), .IDX_W(IDX_W)) cmd_i (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .cmd_we      (cmd_we),
    .cmd_word    (reg_wdata[CW_W-1:0]),
    .arg_in      (arg_q),
    .dat_busy    (dat_busy),
    .resp_end    (cmd_resp_end),
    .cmd_valid_q (cmd_valid),
    .cmd_index_q (cmd_index),
    .cmd_arg_q   (cmd_arg),
    .rend_evt    (rend_evt)
  );

  sdwr_dat #(.DATA_W(DATA_W), .LEN_W(LEN_W), .TMO_W(TMO_W)) dat_i (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .dctl_we   (dctl_we),
    .dctl_word (reg_wdata[DC_W-1:0]),
    .len_in    (len_q),
    .tmo_in    (tmo_q),
    .rend_flag (status[ST_REND]),
    .src_valid (src_valid),
    .src_data  (src_data),
    .dat_ready (dat_ready),
    .busy_q    (dat_busy),
    .src_ready (src_ready),
    .dat_valid (dat_valid),
    .dat_word  (dat_word),
    .done_evt  (done_evt),
    .tmo_evt   (tmo_evt),
    .rej_evt   (rej_evt)
  );

  // R4: a response end retires the command and raises its flag
  p_rend_flag_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (cmd_valid && cmd_resp_end) |=> (status[ST_REND] && !cmd_valid));

  // R5: the data window never opens without the response-end flag
  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(dat_busy) |-> status[ST_REND]);

  // R7: a closing window leaves a block-end or timeout flag behind
  p_close_flag_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    $fell(dat_busy) |-> (status[ST_BEND] || status[ST_TMO]));

endmodule

// File: tb/sdwr_seq_tb_top.sv
module sdwr_seq_tb_top;

  localparam int DATA_W = 32;
  localparam int NV     = 13;
  localparam int WD_LIM = 100000;
  localparam logic [1:0] RS_DONE = 2'd0, RS_REJ = 2'd1, RS_TMO = 2'd2, RS_NONE = 2'd3;

  typedef struct packed {
    logic [15:0] len;
    logic [3:0]  code;
    logic [3:0]  flags;  // {dma, mode, dir, en}
    logic [15:0] tmo;
    logic [1:0]  rdy;    // 0 always, 1 alternating, 2 never
    logic [1:0]  res;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{16'd512, 4'd9, 4'b1001, 16'd1000, 2'd0, RS_DONE},
    '{16'd64,  4'd4, 4'b1001, 16'd500,  2'd1, RS_DONE},
    '{16'd100, 4'd4, 4'b1001, 16'd500,  2'd0, RS_REJ},
    '{16'd64,  4'd6, 4'b1011, 16'd500,  2'd0, RS_REJ},
    '{16'd64,  4'd6, 4'b1101, 16'd500,  2'd0, RS_REJ},
    '{16'd64,  4'd6, 4'b0001, 16'd500,  2'd0, RS_REJ},
    '{16'd64,  4'd6, 4'b1001, 16'd10,   2'd2, RS_TMO},
    '{16'd64,  4'd6, 4'b1000, 16'd500,  2'd0, RS_NONE},
    '{16'd0,   4'd6, 4'b1001, 16'd500,  2'd0, RS_REJ},
    '{16'd64,  4'd6, 4'b1001, 16'd0,    2'd0, RS_REJ},
    '{16'd8,   4'd1, 4'b1001, 16'd500,  2'd0, RS_REJ},
    '{16'd4,   4'd2, 4'b1001, 16'd50,   2'd0, RS_DONE},
    '{16'd64,  4'd6, 4'b1001, 16'd20,   2'd1, RS_TMO}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              reg_we;
  logic [2:0]        reg_addr;
  logic [DATA_W-1:0] reg_wdata;
  logic [11:0]       status;
  logic              cmd_valid;
  logic [5:0]        cmd_index;
  logic [DATA_W-1:0] cmd_arg;
  logic              cmd_resp_end;
  logic              src_valid;
  logic [DATA_W-1:0] src_data;
  logic              src_ready;
  logic              dat_valid;
  logic [DATA_W-1:0] dat_word;
  logic              dat_ready;
  logic              dat_busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  sdwr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .status(status), .cmd_valid(cmd_valid),
    .cmd_index(cmd_index), .cmd_arg(cmd_arg), .cmd_resp_end(cmd_resp_end),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .dat_valid(dat_valid), .dat_word(dat_word), .dat_ready(dat_ready),
    .dat_busy(dat_busy)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WD_LIM) begin
      errors = errors + 1;
      $display("FAIL watchdog (all requirements) actual=%0d expected<=%0d", cycles, WD_LIM);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic resp_pulse();
    cmd_resp_end = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_resp_end = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int v, input int w);
    return {8'(v), 24'(w)} ^ 32'h5A5A_0000;
  endfunction

  task automatic run_vec(input int v);
    vec_t t = VECS[v];
    int widx = 0;
    int bcyc = 0;
    bit hs;
    reg_wr(3'd5, 32'hFFF);
    reg_wr(3'd0, 32'(t.len));
    reg_wr(3'd1, 32'hA000_0000 + 32'(v));
    reg_wr(3'd2, 32'(t.tmo));
    reg_wr(3'd3, 32'h0000_00D8);              // index 24, wait-resp, enable
    chk("R2", "cmd_valid", 32'(cmd_valid), 32'd1);
    chk("R2", "cmd_index", 32'(cmd_index), 32'd24);
    chk("R2", "cmd_arg", cmd_arg, 32'hA000_0000 + 32'(v));
    idle(2);
    chk("R2", "cmd_valid held", 32'(cmd_valid), 32'd1);
    resp_pulse();
    chk("R4", "cmd_valid after resp", 32'(cmd_valid), 32'd0);
    chk("R4", "status bit6", 32'(status[6]), 32'd1);
    src_data  = pat(v, 0);
    dat_ready = (t.rdy == 2'd2) ? 1'b0 : 1'b1;
    reg_wr(3'd4, {24'd0, t.code, t.flags});
    chk("R6", "dat_busy after dctl", 32'(dat_busy),
        32'((t.res == RS_DONE) || (t.res == RS_TMO)));
    while (dat_busy && bcyc < 5000) begin
      bcyc = bcyc + 1;
      case (t.rdy)
        2'd0:    dat_ready = 1'b1;
        2'd1:    dat_ready = bcyc[0];
        default: dat_ready = 1'b0;
      endcase
      #1;
      hs = dat_valid && src_ready;
      if (hs) chk("R7", "dat_word", dat_word, pat(v, widx));
      @(posedge clk); @(negedge clk);
      if (hs) begin
        widx = widx + 1;
        src_data = pat(v, widx);
      end
    end
    case (t.res)
      RS_DONE: begin
        chk("R7", "words moved", 32'(widx), 32'(t.len) >> 2);
        chk("R7", "status bit10", 32'(status[10]), 32'd1);
        chk("R7", "src_ready after end", 32'(src_ready), 32'd0);
        chk("R9", "no timeout flag", 32'(status[3]), 32'd0);
      end
      RS_TMO: begin
        chk("R9", "window cycles", 32'(bcyc), 32'(t.tmo));
        chk("R9", "status bit3", 32'(status[3]), 32'd1);
        chk("R9", "no block end", 32'(status[10]), 32'd0);
      end
      RS_REJ: begin
        chk("R8", "status bit11", 32'(status[11]), 32'd1);
        chk("R8", "no window", 32'(dat_busy), 32'd0);
        chk("R8", "no block end", 32'(status[10]), 32'd0);
      end
      default: begin
        chk("R6", "disabled dctl leaves status", 32'(status), 32'h040);
        chk("R6", "disabled dctl no window", 32'(dat_busy), 32'd0);
      end
    endcase
    dat_ready = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    cmd_resp_end = 1'b0; src_valid = 1'b1; src_data = '0; dat_ready = 1'b1;
    idle(3);
    chk("R1", "status in reset", 32'(status), 32'd0);
    chk("R1", "cmd_valid in reset", 32'(cmd_valid), 32'd0);
    rst_n = 1'b1;
    idle(4);
    chk("R1", "status", 32'(status), 32'd0);
    chk("R1", "cmd_valid", 32'(cmd_valid), 32'd0);
    chk("R1", "src_ready", 32'(src_ready), 32'd0);
    chk("R1", "dat_valid", 32'(dat_valid), 32'd0);
    chk("R1", "dat_busy", 32'(dat_busy), 32'd0);

    // R5: legal data-control before any response end
    reg_wr(3'd0, 32'd64);
    reg_wr(3'd2, 32'd100);
    reg_wr(3'd4, 32'h0000_0069);
    chk("R5", "no window", 32'(dat_busy), 32'd0);
    chk("R5", "src_ready low", 32'(src_ready), 32'd0);
    chk("R5", "status unchanged", 32'(status), 32'd0);

    // R3: command words missing a launch flag
    reg_wr(3'd3, 32'h0000_0098);
    chk("R3", "no launch without wait-resp", 32'(cmd_valid), 32'd0);
    reg_wr(3'd3, 32'h0000_0058);
    chk("R3", "no launch without enable", 32'(cmd_valid), 32'd0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R10: set and clear in the same cycle; set wins
    reg_wr(3'd5, 32'hFFF);
    reg_wr(3'd3, 32'h0000_00D8);
    reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h040; cmd_resp_end = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; cmd_resp_end = 1'b0;
    chk("R10", "set wins over clear", 32'(status[6]), 32'd1);
    idle(5);
    chk("R11", "flag sticky", 32'(status[6]), 32'd1);
    reg_wr(3'd5, 32'h008);
    chk("R10", "clear of other bit keeps bit6", 32'(status), 32'h040);
    reg_wr(3'd5, 32'h040);
    chk("R10", "cleared", 32'(status), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule